// File: doc/BRIEF.md
# Four-Entry Synchronous FIFO Buffer

This block is a small first-in-first-out queue that stores up to four 64-bit words, all on one clock. A producer offers a word by raising a push strobe with the data. A consumer sees the oldest stored word at all times and removes it by raising a pop strobe. Full and empty flags give the occupancy. An error flag reports an internal state that a correct design can never reach.

The block fixes the result of every combination of push and pop at each fill level. When the queue is empty, a push and a pop in the same cycle stores the word and ignores the pop. When the queue is full, the same pair removes the head and drops the incoming word. In every other case both take place. No input reaches an output in the same cycle. Every output comes from registered state, so outputs change only after a rising clock edge.

Top module: `fifo4x64`

## Requirements
- R1: While reset (active high, synchronous) is applied and in the cycle after it, the queue is empty: `isEmpty`=1, `isFull`=0, `headData`=0, `errFlag`=0.
- R2: A push while the queue is not full stores `pushData`. After the edge, the queue holds one more entry and `isEmpty` is 0.
- R3: Words leave the queue in the order they were accepted. `headData` always shows the oldest stored word.
- R4: A push without a pop while the queue is full is ignored. `isFull` stays 1 and `headData` is unchanged.
- R5: A pop without a push while the queue is empty has no effect. `isEmpty` stays 1.
- R6: A push and a pop in the same cycle with one to three entries stored are both performed. The count is unchanged and the head advances to the next word.
- R7: A push and a pop in the same cycle on an empty queue store the word and ignore the pop. During that cycle `isEmpty` stays 1 and `headData` stays 0. After the edge the pushed word is at the head.
- R8: A push and a pop in the same cycle on a full queue remove the head and drop the incoming word, which leaves three entries.
- R9: `isFull` is 1 exactly when four entries are stored, and `isEmpty` is 1 exactly when none are. Both depend only on occupancy and never on the strobes in the current cycle.
- R10: `headData` is all zeros whenever the queue is empty.
- R11: `errFlag` is 1 only if the occupancy exceeds four or disagrees with the pointer distance. In normal operation it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pushValid | input | 1 | Offer `pushData` for storage this cycle |
| pushData | input | 64 | Word to store |
| popReq | input | 1 | Remove the head word this cycle |
| headData | output | 64 | Oldest stored word, zero when empty |
| isFull | output | 1 | Four entries stored |
| isEmpty | output | 1 | No entries stored |
| errFlag | output | 1 | Impossible internal state detected |

## Verification
A push and a pop can fall in the same cycle, and the outcome depends on the fill level. The bench therefore issues both strobes together on an empty queue, on a partly filled queue and on a full queue. It also repeats them in a long pseudo-random mix. A reference queue in the bench applies the rules of R6 to R8 and compares head word and flags after each edge. Before each edge it checks that the flags and head have not yet moved, which shows that on an empty queue neither the pop nor the bypass takes effect.

// File: rtl/fifo4_pkg.sv
package fifo4_pkg;
  parameter int DATA_W = 64;
  parameter int DEPTH  = 4;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;
    logic             showHead;
  } fifoStrobes_t;
endpackage

// File: rtl/fifo4_ctrl.sv
module fifo4_ctrl
  import fifo4_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         pushValid,
  input  logic         popReq,
  output fifoStrobes_t strb,
  output logic         isFull,
  output logic         isEmpty,
  output logic         errFlag
);
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             doPush;
  logic             doPop;
  logic [PTR_W-1:0] ptrGap;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);

  // full drops the push, empty drops the pop; both cover the joint cases
  assign doPush = pushValid && !isFull;
  assign doPop  = popReq && !isEmpty;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign ptrGap  = wrPtr - rdPtr;
  assign errFlag = (count > CNT_W'(DEPTH)) || (ptrGap != count[PTR_W-1:0]);

  always_comb begin
    strb.wrEn     = doPush;
    strb.wrPtr    = wrPtr;
    strb.rdPtr    = rdPtr;
    strb.showHead = !isEmpty;
  end
endmodule

// File: rtl/fifo4_data.sv
module fifo4_data
  import fifo4_pkg::*;
(
  input  logic              clk,
  input  fifoStrobes_t      strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.wrEn && (strb.wrPtr == PTR_W'(e))) slot[e] <= wrData;
    end
  end

  assign headData = strb.showHead ? slot[strb.rdPtr] : '0;
endmodule

// File: rtl/fifo4x64.sv
module fifo4x64
  import fifo4_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] headData,
  output logic              isFull,
  output logic              isEmpty,
  output logic              errFlag
);
  fifoStrobes_t strb;

  fifo4_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pushValid(pushValid),
    .popReq   (popReq),
    .strb     (strb),
    .isFull   (isFull),
    .isEmpty  (isEmpty),
    .errFlag  (errFlag)
  );

  fifo4_data i_data (
    .clk     (clk),
    .strb    (strb),
    .wrData  (pushData),
    .headData(headData)
  );
endmodule

// File: rtl/fifo4x64_checker.sv
module fifo4x64_checker
  import fifo4_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pushValid,
  input logic [DATA_W-1:0] pushData,
  input logic              popReq,
  input logic [DATA_W-1:0] headData,
  input logic              isFull,
  input logic              isEmpty,
  input logic              errFlag
);
  assert_full_push_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (isFull && pushValid && !popReq) |=> (isFull && $stable(headData)));

  assert_empty_pop_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (isEmpty && popReq && !pushValid) |=> isEmpty);

  assert_empty_accepts_R7: assert property (@(posedge clk) disable iff (rst)
    (isEmpty && pushValid) |=> !isEmpty);

  assert_full_pops_only_R8: assert property (@(posedge clk) disable iff (rst)
    (isFull && pushValid && popReq) |=> (!isFull && !isEmpty));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(isFull && isEmpty));

  assert_zero_head_R10: assert property (@(posedge clk) disable iff (rst)
    isEmpty |-> (headData == '0));

  assert_no_error_R11: assert property (@(posedge clk) disable iff (rst)
    !errFlag);
endmodule

bind fifo4x64 fifo4x64_checker i_chk (.*);

// File: tb/test_fifo4x64.sv
module test_fifo4x64;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pushValid = 1'b0;
  logic [63:0] pushData = '0;
  logic        popReq = 1'b0;
  logic [63:0] headData;
  logic        isFull;
  logic        isEmpty;
  logic        errFlag;

  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 1'b0;
  logic [63:0] model[$];
  logic [31:0] lfsr = 32'hACE1_2B37;

  always #5 clk = ~clk;

  fifo4x64 i_fifo4x64 (
    .clk(clk), .rst(rst), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .headData(headData), .isFull(isFull),
    .isEmpty(isEmpty), .errFlag(errFlag)
  );

  task automatic compare(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor side: compare all outputs against the reference queue
  task automatic checkAll(input string tag);
    logic [63:0] expHead;
    expHead = (model.size() != 0) ? model[0] : 64'h0;
    compare(tag, "headData", headData, expHead);
    compare(tag, "isFull",  {63'h0, isFull},  {63'h0, model.size() == 4});
    compare(tag, "isEmpty", {63'h0, isEmpty}, {63'h0, model.size() == 0});
    compare("R11", "errFlag", {63'h0, errFlag}, 64'h0);
  endtask

  // driver side: apply one cycle, update the reference queue at the edge
  task automatic step(input string tag, input bit p, input logic [63:0] d,
                      input bit q);
    bit acceptPush, acceptPop;
    @(negedge clk);
    pushValid = p; pushData = d; popReq = q;
    #1;
    checkAll("R9");            // outputs must not react before the edge
    acceptPush = p && (model.size() < 4);
    acceptPop  = q && (model.size() > 0);
    @(posedge clk);
    if (acceptPop)  void'(model.pop_front());
    if (acceptPush) model.push_back(d);
    @(negedge clk);
    pushValid = 1'b0; popReq = 1'b0;
    checkAll(tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    checkAll("R1");
    @(negedge clk);
    rst = 1'b0;
    checkAll("R1");

    step("R5", 0, 64'h0, 1);
    step("R5", 0, 64'h0, 1);
    step("R2", 1, 64'h1111_0000_0000_000A, 0);
    step("R2", 1, 64'h2222_0000_0000_000B, 0);
    step("R2", 1, 64'h3333_0000_0000_000C, 0);
    step("R9", 1, 64'h4444_0000_0000_000D, 0);
    step("R4", 1, 64'hDEAD_BEEF_DEAD_BEEF, 0);
    step("R8", 1, 64'hBAD0_BAD0_BAD0_BAD0, 1);
    step("R6", 1, 64'h5555_0000_0000_000E, 1);
    step("R6", 1, 64'h6666_0000_0000_000F, 1);
    step("R3", 0, 64'h0, 1);
    step("R3", 0, 64'h0, 1);
    step("R3", 0, 64'h0, 1);
    step("R10", 0, 64'h0, 1);
    // joint push and pop on an empty queue: no bypass, pop ignored
    @(negedge clk);
    pushValid = 1'b1; pushData = 64'h7777_ABCD_0000_0001; popReq = 1'b1;
    #1;
    compare("R7", "isEmpty during cycle", {63'h0, isEmpty}, 64'h1);
    compare("R7", "headData during cycle", headData, 64'h0);
    @(posedge clk);
    model.push_back(64'h7777_ABCD_0000_0001);
    @(negedge clk);
    pushValid = 1'b0; popReq = 1'b0;
    checkAll("R7");
    step("R3", 0, 64'h0, 1);

    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R3", lfsr[3] | lfsr[7], {lfsr, ~lfsr ^ i}, lfsr[5] & lfsr[9]);
    end

    // reset with data stored
    step("R2", 1, 64'h0123_4567_89AB_CDEF, 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    model.delete();
    @(negedge clk);
    rst = 1'b0;
    checkAll("R1");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule